// File: doc/BRIEF.md
# Dual-Channel Threshold and Rate Alarm

This block watches two selectable sensor sample streams and raises an alarm on each when a condition holds. Every sample source delivers a 14-bit word in a raw and a filtered version, and one common strobe marks a new sample set. Each of the two channels picks one source by a 4-bit code. It then compares either the sample itself (static mode) or the mean change between consecutive samples over a programmable window (rate mode) with a signed threshold. A per-channel polarity bit chooses a strict greater-than or a strict less-than test.

Both alarm results appear as two status bits. Either result can also drive one indicator output. The indicator can be enabled, has a programmable active level, and goes to one of two pins. Control arrives through four register-shaped inputs: a shared control word, a threshold word per channel and a window-count byte per channel.

Top module: `dual_alarm`

## Requirements
- R1: Source code 1..8 selects input k, at bits [(k-1)*14 +: 14] of the sample buses. Alarm 1 takes its code from control bits 11:8 and alarm 2 from bits 15:12. Control bit 4 (alarm 1) and bit 5 (alarm 2) select the filtered bus when set and the raw bus when clear.
- R2: Source codes 0 and 9..15 disable a channel, and its status bit then stays 0.
- R3: In static mode a channel updates its status at each sample strobe. Threshold bits 13:0 hold the limit and bit 15 selects the test (1: sample > limit, 0: sample < limit). Both tests are strict, so equality never alarms. The status changes at the clock edge that samples the strobe.
- R4: Codes 1, 4 and 5 are compared as unsigned 14-bit values. All other codes are compared as 14-bit two's complement, and the threshold is read in the same format.
- R5: Control bit 6 (alarm 1) and bit 7 (alarm 2) select rate mode. After a restart the first sample sets the base. Each later group of N samples closes a window, and the last sample of a group becomes the next base. Only at window close does the status update, to (last − base) > limit·N or < limit·N, which is an exact comparison of the mean difference with the limit.
- R6: The window count N is the channel's 8-bit count input, and the values 0 and 1 both mean one difference.
- R7: A change of a channel's source code, window count or rate-mode bit clears its status and restarts its window. A threshold change does neither.
- R8: The indicator is enabled by control bit 2. Bit 1 sets its level (1: active high) and bit 0 selects the pin (1: pin[1], 0: pin[0]). It is active while either status bit is 1. The unselected pin, and both pins when the indicator is disabled, read 0. The pins follow the status one clock later.
- R9: Status bit 0 reports alarm 1 and bit 1 reports alarm 2. Between strobes and configuration changes the status holds.
- R10: Codes 6, 7 and 8 always use the filtered bus, whatever the filter bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample set strobe |
| raw_samples | input | 112 | Eight raw 14-bit sources, source k at [(k-1)*14 +: 14] |
| filt_samples | input | 112 | Eight filtered 14-bit sources, same layout |
| alm_ctrl | input | 16 | Source, mode, filter and indicator control |
| alm1_thr | input | 16 | Alarm 1 threshold and test polarity |
| alm2_thr | input | 16 | Alarm 2 threshold and test polarity |
| alm1_cnt | input | 8 | Alarm 1 rate window count |
| alm2_cnt | input | 8 | Alarm 2 rate window count |
| alm_status | output | 2 | Alarm status, bit 0 alarm 1, bit 1 alarm 2 |
| alm_pin | output | 2 | Indicator pins |

## Verification
A vector table drives static comparisons in which the chosen source carries the test value and every other source carries exactly the threshold, which can never alarm. A wrong source pick therefore shows up as a missing alarm. Paired vectors on the same bit pattern separate unsigned from two's-complement handling, and others separate raw from filtered paths, the forced-filtered angle codes, equality and the disabled codes. Rate sequences place the difference sum above, below and exactly at limit·N, check that the status stays still inside a window, and cover the 0/1 count and the restart on reconfiguration. Indicator cases walk enable, level and pin choice with the alarm both active and idle.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int SRC_W = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF    = 4'd0,
    SRC_SUPPLY = 4'd1,
    SRC_XACC   = 4'd2,
    SRC_YACC   = 4'd3,
    SRC_AUXADC = 4'd4,
    SRC_TEMP   = 4'd5,
    SRC_XTILT  = 4'd6,
    SRC_YTILT  = 4'd7,
    SRC_ROT    = 4'd8
  } src_e;

  function automatic logic src_live(input logic [SRC_W-1:0] c);
    return (c >= SRC_SUPPLY) && (c <= SRC_ROT);
  endfunction

  function automatic logic src_unsigned(input logic [SRC_W-1:0] c);
    return (c == SRC_SUPPLY) || (c == SRC_AUXADC) || (c == SRC_TEMP);
  endfunction

  function automatic logic src_force_filt(input logic [SRC_W-1:0] c);
    return (c == SRC_XTILT) || (c == SRC_YTILT) || (c == SRC_ROT);
  endfunction
endpackage

// File: rtl/alarm_src_mux.sv
module alarm_src_mux
  import alarm_pkg::*;
#(
  parameter int DW   = 14,
  parameter int NSRC = 8
) (
  input  logic [NSRC*DW-1:0] raw_bus,
  input  logic [NSRC*DW-1:0] filt_bus,
  input  logic [SRC_W-1:0]   code,
  input  logic               want_filt,
  output logic [DW-1:0]      sample
);
  logic use_filt;
  assign use_filt = want_filt | src_force_filt(code);   // R10

  always_comb begin
    sample = '0;
    for (int k = 1; k <= NSRC; k++) begin
      if (code == SRC_W'(k))
        sample = use_filt ? filt_bus[(k-1)*DW +: DW] : raw_bus[(k-1)*DW +: DW];
    end
  end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
  import alarm_pkg::*;
#(
  parameter int DW = 14,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [DW-1:0]    sample,
  input  logic [SRC_W-1:0] code,
  input  logic [15:0]      thr,
  input  logic [CW-1:0]    cnt_cfg,
  input  logic             rate_en,
  output logic             alarm
);
  localparam int EW   = DW + 2;
  localparam int PW   = EW + CW + 1;
  localparam int CFGW = SRC_W + CW + 1;

  logic [CFGW-1:0]       cfg_now, cfg_q;
  logic                  changed, in_use, uns, gt;
  logic [CW-1:0]         nwin, cnt_q;
  logic                  have_base;
  logic signed [EW-1:0]  s_x, t_x, base_q, diff;
  logic signed [PW-1:0]  diff_w, t_w, n_w, scaled;
  logic                  hit_static, hit_rate;
  logic                  unused_thr;

  assign unused_thr = thr[14];
  assign cfg_now    = {code, cnt_cfg, rate_en};
  assign changed    = cfg_now != cfg_q;
  assign in_use     = src_live(code);
  assign uns        = src_unsigned(code);
  assign gt         = thr[15];
  assign nwin       = (cnt_cfg == '0) ? CW'(1) : cnt_cfg;   // R6

  always_comb begin
    s_x = uns ? {2'b00, sample}     : {{2{sample[DW-1]}}, sample};
    t_x = uns ? {2'b00, thr[DW-1:0]} : {{2{thr[DW-1]}}, thr[DW-1:0]};
  end

  assign diff   = s_x - base_q;
  assign diff_w = PW'(diff);
  assign t_w    = PW'(t_x);
  assign n_w    = PW'($signed({1'b0, nwin}));
  assign scaled = t_w * n_w;

  assign hit_static = gt ? (s_x > t_x) : (s_x < t_x);
  assign hit_rate   = gt ? (diff_w > scaled) : (diff_w < scaled);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      alarm     <= 1'b0;
      have_base <= 1'b0;
      cnt_q     <= '0;
      base_q    <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (changed) begin
        alarm     <= 1'b0;
        have_base <= 1'b0;
        cnt_q     <= '0;
      end else if (valid) begin
        if (!in_use) begin
          alarm <= 1'b0;
        end else if (!rate_en) begin
          alarm <= hit_static;
        end else if (!have_base) begin
          base_q    <= s_x;
          have_base <= 1'b1;
          cnt_q     <= '0;
        end else if (CW'(cnt_q + 1'b1) == nwin) begin
          alarm  <= hit_rate;
          base_q <= s_x;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: reconfiguration clears the channel
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    changed |=> !alarm);
  // R9: status holds without strobe or reconfiguration
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid && !changed) |=> $stable(alarm));
  // R2: a disabled channel never alarms after a strobe
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid && !in_use && !changed) |=> !alarm);
  // R5: the window position stays below the count
  a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
    (have_base && !changed) |-> (cnt_q < nwin));
endmodule

// File: rtl/alarm_indicator.sv
module alarm_indicator (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] alarms,
  input  logic       en,
  input  logic       pol,
  input  logic       sel,
  output logic [1:0] pins
);
  logic lvl;
  assign lvl = pol ? (|alarms) : ~(|alarms);

  always_ff @(posedge clk) begin
    if (rst)      pins <= 2'b00;
    else if (!en) pins <= 2'b00;
    else          pins <= sel ? {lvl, 1'b0} : {1'b0, lvl};
  end

  // R8: a disabled indicator leaves both pins low
  a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pins == 2'b00));
  // R8: at most one pin is ever driven high
  a_r8_one_pin: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pins));
  // R8: an active-high indicator with an alarm raises a pin
  a_r8_active_high: assert property (@(posedge clk) disable iff (rst)
    (en && pol && (|alarms)) |=> (|pins));
endmodule

// File: rtl/dual_alarm.sv
module dual_alarm
  import alarm_pkg::*;
#(
  parameter int DW   = 14,
  parameter int NSRC = 8,
  parameter int CW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic [NSRC*DW-1:0] raw_samples,
  input  logic [NSRC*DW-1:0] filt_samples,
  input  logic [15:0]        alm_ctrl,
  input  logic [15:0]        alm1_thr,
  input  logic [15:0]        alm2_thr,
  input  logic [CW-1:0]      alm1_cnt,
  input  logic [CW-1:0]      alm2_cnt,
  output logic [1:0]         alm_status,
  output logic [1:0]         alm_pin
);
  localparam int NCH = 2;

  logic unused_ctrl;
  assign unused_ctrl = alm_ctrl[3];

  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0]    smp;
    logic [SRC_W-1:0] code;
    logic [15:0]      thr;
    logic [CW-1:0]    cnt;

    assign code = alm_ctrl[8 + SRC_W*i +: SRC_W];
    assign thr  = (i == 0) ? alm1_thr : alm2_thr;
    assign cnt  = (i == 0) ? alm1_cnt : alm2_cnt;

    alarm_src_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
      .raw_bus   (raw_samples),
      .filt_bus  (filt_samples),
      .code      (code),
      .want_filt (alm_ctrl[4+i]),
      .sample    (smp)
    );

    alarm_channel #(.DW(DW), .CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .valid   (smp_valid),
      .sample  (smp),
      .code    (code),
      .thr     (thr),
      .cnt_cfg (cnt),
      .rate_en (alm_ctrl[6+i]),
      .alarm   (hit[i])
    );
  end

  assign alm_status = hit;

  alarm_indicator u_ind (
    .clk    (clk),
    .rst    (rst),
    .alarms (hit),
    .en     (alm_ctrl[2]),
    .pol    (alm_ctrl[1]),
    .sel    (alm_ctrl[0]),
    .pins   (alm_pin)
  );
endmodule

// File: tb/tb_dual_alarm.sv
module tb_dual_alarm;
  localparam int DW = 14;
  localparam int NSRC = 8;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [NSRC*DW-1:0] raw_samples = '0;
  logic [NSRC*DW-1:0] filt_samples = '0;
  logic [15:0] alm_ctrl = '0;
  logic [15:0] alm1_thr = '0;
  logic [15:0] alm2_thr = '0;
  logic [7:0]  alm1_cnt = '0;
  logic [7:0]  alm2_cnt = '0;
  logic [1:0]  alm_status;
  logic [1:0]  alm_pin;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_alarm dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .raw_samples(raw_samples), .filt_samples(filt_samples),
    .alm_ctrl(alm_ctrl), .alm1_thr(alm1_thr), .alm2_thr(alm2_thr),
    .alm1_cnt(alm1_cnt), .alm2_cnt(alm2_cnt),
    .alm_status(alm_status), .alm_pin(alm_pin)
  );

  // {code, filter bit, threshold word, raw value, filtered value, expected alarm 1}
  localparam logic [49:0] VEC [NV] = '{
    {4'd2, 1'b0, 16'h8064, 14'd200,    14'd0,      1'b1}, // R3 gt above
    {4'd2, 1'b0, 16'h8064, 14'd50,     14'd0,      1'b0}, // R3 gt below
    {4'd2, 1'b0, 16'h0064, 14'd50,     14'd0,      1'b1}, // R3 lt below
    {4'd2, 1'b0, 16'h8064, 14'd100,    14'd0,      1'b0}, // R3 equality
    {4'd2, 1'b0, 16'hBFFB, 14'h3FFD,   14'd0,      1'b1}, // R4 signed -3 > -5
    {4'd1, 1'b0, 16'h8100, 14'h3FFD,   14'd0,      1'b1}, // R4 unsigned big
    {4'd2, 1'b0, 16'h8100, 14'h3FFD,   14'd0,      1'b0}, // R4 same bits signed
    {4'd5, 1'b0, 16'h04FE, 14'h0400,   14'd0,      1'b1}, // R4 unsigned lt
    {4'd3, 1'b1, 16'h800A, 14'd0,      14'd20,     1'b1}, // R1 filtered path
    {4'd3, 1'b0, 16'h800A, 14'd0,      14'd20,     1'b0}, // R1 raw path
    {4'd6, 1'b0, 16'h800A, 14'd0,      14'd20,     1'b1}, // R10 forced filter
    {4'd8, 1'b0, 16'h3F9C, 14'd0,      14'h3F38,   1'b1}, // R10 rotation lt -100
    {4'd0, 1'b0, 16'hBFFB, 14'd0,      14'd0,      1'b0}, // R2 code 0
    {4'd12,1'b0, 16'hBFFB, 14'd0,      14'd0,      1'b0}, // R2 code 12
    {4'd4, 1'b0, 16'h8000 | 16'h2000, 14'h2001, 14'd0, 1'b1}, // R1 aux source
    {4'd7, 1'b1, 16'h0000, 14'd0,      14'h3FFF,   1'b1}  // R4 signed -1 < 0
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe();
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic fill_all(input logic [13:0] rv, input logic [13:0] fv);
    for (int k = 0; k < NSRC; k++) begin
      raw_samples[k*DW +: DW]  = rv;
      filt_samples[k*DW +: DW] = fv;
    end
  endtask

  task automatic rate_step(input logic [13:0] v);
    fill_all(v, v);
    strobe();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset status", alm_status, 2'b00);
    check("R8 reset pins", alm_pin, 2'b00);

    // Static comparison table on alarm 1 (R1 R2 R3 R4 R10)
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  code;
      logic [15:0] thr;
      logic [13:0] rv, fv;
      code = VEC[v][49:46];
      thr  = VEC[v][44:29];
      rv   = VEC[v][28:15];
      fv   = VEC[v][14:1];
      alm_ctrl = {4'd0, code, 3'b000, VEC[v][45], 4'b0000};
      alm1_thr = thr;
      for (int k = 1; k <= NSRC; k++) begin
        raw_samples[(k-1)*DW +: DW]  = (k == int'(code)) ? rv : thr[13:0];
        filt_samples[(k-1)*DW +: DW] = (k == int'(code)) ? fv : thr[13:0];
      end
      settle();
      strobe();
      check($sformatf("R3 table entry %0d", v), alm_status, {1'b0, VEC[v][0]});
    end

    // R5 rate mode, window of 3, limit 10 (threshold 30)
    alm_ctrl = 16'h0240;
    alm1_cnt = 8'd3;
    alm1_thr = 16'h800A;
    settle();
    rate_step(14'd0);
    rate_step(14'd10);
    rate_step(14'd20);
    check("R5 no alarm before window fills", alm_status, 2'b00);
    rate_step(14'd40);
    check("R5 sum 40 above 30", alm_status, 2'b01);
    rate_step(14'd50);
    check("R9 held inside window", alm_status, 2'b01);
    rate_step(14'd60);
    rate_step(14'd60);
    check("R5 sum 20 below 30", alm_status, 2'b00);
    rate_step(14'd70);
    rate_step(14'd80);
    rate_step(14'd90);
    check("R5 sum equal to limit times N", alm_status, 2'b00);

    // R6 count 0 means one difference
    alm1_cnt = 8'd0;
    alm1_thr = 16'h8005;
    settle();
    rate_step(14'd0);
    check("R6 first sample only sets base", alm_status, 2'b00);
    rate_step(14'd10);
    check("R6 count 0 diff 10", alm_status, 2'b01);
    rate_step(14'd12);
    check("R6 count 0 diff 2", alm_status, 2'b00);
    rate_step(14'd30);
    check("R6 count 0 diff 18", alm_status, 2'b01);

    // R7 count change clears and restarts
    alm1_cnt = 8'd1;
    settle();
    check("R7 cleared on count change", alm_status, 2'b00);
    rate_step(14'd40);
    check("R7 restart takes a new base", alm_status, 2'b00);
    rate_step(14'd50);
    check("R6 count 1 diff 10", alm_status, 2'b01);
    alm1_thr = 16'h8030;
    settle();
    check("R7 threshold change keeps status", alm_status, 2'b01);

    // Alarm 2 placement and its filter bit (R1 R9)
    alm_ctrl = 16'h3020;
    alm2_thr = 16'h8000;
    fill_all(14'd0, 14'd9);
    settle();
    strobe();
    check("R1 alarm 2 filtered source", alm_status, 2'b10);

    // Indicator (R8)
    alm_ctrl = 16'h3026;
    settle();
    check("R8 active high pin 0", alm_pin, 2'b01);
    alm_ctrl = 16'h3027;
    settle();
    check("R8 active high pin 1", alm_pin, 2'b10);
    alm_ctrl = 16'h3025;
    settle();
    check("R8 active low asserted", alm_pin, 2'b00);
    fill_all(14'd0, 14'd0);
    strobe();
    check("R9 alarm 2 cleared", alm_status, 2'b00);
    @(negedge clk);
    check("R8 active low idle", alm_pin, 2'b10);
    alm_ctrl = 16'h3020;
    settle();
    check("R8 disabled pins low", alm_pin, 2'b00);

    finish_run();
  end
endmodule